// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into CAN bit timing for a receiver. A programmable divider produces one time-quantum tick every (prescale + 1) clocks. Each bit is built from quanta: one synchronisation quantum, a first segment of (seg1 + 1) quanta and a second segment of (seg2 + 1) quanta. The receive line is sampled at the end of the first segment. The block then gives a one-clock strobe and the decided bit value. The value is taken either from a single sample or from a 2-of-3 vote over the last three quanta.

Falling edges on the receive line, from recessive (1) to dominant (0), are compared with the expected bit start. The block resynchronises to them by stretching the first segment or cutting the second segment, by at most a programmed jump width. A bus-idle input turns any such edge into a hard synchronisation, which restarts the bit without a limit.

The timing fields can be written only while the configuration-mode input is high. They can be read back at any time. While that input is high the timing engine is held at the start of a bit and produces no strobes.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the read-back fields are: prescale 0, jump width 0, seg1 3, seg2 2, triple-sample 0.
- R2: A write pulse on cfg_we updates the timing fields only if cfg_mode is high on the same clock. With cfg_mode low, the read-back values and the bit timing stay unchanged.
- R3: While cfg_mode is high, sample_stb stays low. The bit engine restarts at the synchronisation quantum when cfg_mode falls.
- R4: One quantum lasts (prescale + 1) clocks. One bit lasts (seg1 + seg2 + 3) quanta. Without falling edges, consecutive strobes are exactly that many clocks apart.
- R5: The sample is taken at the last quantum of the first segment. sample_stb is a single-clock pulse, and bit_val changes only in the cycle where sample_stb is high. In single mode (triple-sample 0), bit_val is the registered receive level at the sample point.
- R6: A falling edge in quantum k (counting from 0) of the first segment lengthens that segment by min(jump + 1, k + 1) quanta.
- R7: A falling edge in quantum k of the second segment works as follows. If at most `jump` second-segment quanta remain after it, the bit ends and that quantum acts as the next synchronisation quantum. Otherwise the second segment is cut by (jump + 1) quanta.
- R8: A falling edge in the synchronisation quantum leaves the bit length unchanged.
- R9: At most one resynchronisation takes effect per bit. A second falling edge later in the same bit is ignored.
- R10: A rising edge (0 to 1) never changes the bit timing.
- R11: With triple-sample 1, bit_val is the 2-of-3 majority of the receive level in the last three quanta up to and including the sample point. A one-quantum spike is rejected, and a two-quantum level is accepted.
- R12: While bus_idle is high, a falling edge restarts the bit at the end of the edge quantum, which becomes the synchronisation quantum, with no jump-width limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode: unlocks writes and holds the bit engine |
| cfg_we | input | 1 | Write pulse for the timing fields |
| cfg_prescale | input | BRP_W | Prescaler value to write |
| cfg_sjw | input | SJW_W | Jump width value to write (effective jump = value + 1) |
| cfg_seg1 | input | TS1_W | First segment value to write (length = value + 1) |
| cfg_seg2 | input | TS2_W | Second segment value to write (length = value + 1) |
| cfg_triple | input | 1 | Sample mode to write: 0 single, 1 majority of three |
| bus_idle | input | 1 | Bus idle: falling edges cause hard synchronisation |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| sample_stb | output | 1 | One-clock pulse at each sample point |
| bit_val | output | 1 | Decided bit value, updated with sample_stb |
| rd_prescale | output | BRP_W | Current prescaler field |
| rd_sjw | output | SJW_W | Current jump width field |
| rd_seg1 | output | TS1_W | Current first segment field |
| rd_seg2 | output | TS2_W | Current second segment field |
| rd_triple | output | 1 | Current sample mode |

## Verification
The assertions check four rules on every cycle: the fields are frozen unless a write arrives in configuration mode, no strobe appears in configuration mode, each strobe lasts one clock and follows a quantum tick, and bit_val moves only with a strobe. The numeric effects can only be shown by the directed scenarios, which place falling and rising edges in chosen quanta and measure the spacing between strobes. These effects are the bit length, the lengthening and shortening amounts, the one-resync limit, the hard-sync restart and the majority vote against short spikes.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int BRP_W   = 6,
  parameter int SJW_W   = 2,
  parameter int TS1_W   = 4,
  parameter int TS2_W   = 3,
  parameter int TS1_RST = 3,
  parameter int TS2_RST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unlock,
  input  logic             we,
  input  logic [BRP_W-1:0] wr_brp,
  input  logic [SJW_W-1:0] wr_sjw,
  input  logic [TS1_W-1:0] wr_ts1,
  input  logic [TS2_W-1:0] wr_ts2,
  input  logic             wr_tri,
  output logic [BRP_W-1:0] brp,
  output logic [SJW_W-1:0] sjw,
  output logic [TS1_W-1:0] ts1,
  output logic [TS2_W-1:0] ts2,
  output logic             tri_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brp      <= '0;
      sjw      <= '0;
      ts1      <= TS1_W'(TS1_RST);
      ts2      <= TS2_W'(TS2_RST);
      tri_mode <= 1'b0;
    end else if (we && unlock) begin
      brp      <= wr_brp;
      sjw      <= wr_sjw;
      ts1      <= wr_ts1;
      ts2      <= wr_ts2;
      tri_mode <= wr_tri;
    end
  end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  logic [BRP_W-1:0] cnt;

  assign tick = !hold && (cnt == brp);

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else if (cnt == brp) cnt <= '0;
    else cnt <= cnt + BRP_W'(1);
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tick,
  input  logic rx_in,
  input  logic tri_mode,
  output logic fall_edge,
  output logic level
);
  logic       rx_q;
  logic [1:0] hist;
  logic       vote;

  always_ff @(posedge clk) begin
    if (rst) rx_q <= 1'b1;
    else     rx_q <= rx_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       hist <= 2'b11;
    else if (hold) hist <= {rx_q, rx_q};
    else if (tick) hist <= {hist[0], rx_q};
  end

  assign vote      = (hist[1] & hist[0]) | (hist[1] & rx_q) | (hist[0] & rx_q);
  assign fall_edge = hist[0] & ~rx_q;
  assign level     = tri_mode ? vote : rx_q;
endmodule

// File: rtl/can_bt_engine.sv
module can_bt_engine
  import can_bt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             fall_edge,
  input  logic             hard_en,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  output logic             smp_now
);
  localparam int SEGW = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int QW   = ((SEGW > SJW_W) ? SEGW : SJW_W) + 2;

  bt_phase_t       ph, ph_n;
  logic [QW-1:0]   qcnt, q_n;
  logic [QW-1:0]   ext, ext_n;
  logic [QW-1:0]   cut, cut_n;
  logic            done, done_n;
  logic [QW-1:0]   jump, perr, left;
  logic            resync;

  assign jump   = QW'(sjw) + QW'(1);
  assign perr   = qcnt + QW'(1);
  assign left   = QW'(ts2) - qcnt;
  assign resync = fall_edge && !done;

  always_comb begin
    ph_n    = ph;
    q_n     = qcnt;
    ext_n   = ext;
    cut_n   = cut;
    done_n  = done;
    smp_now = 1'b0;
    if (tick) begin
      if (hard_en && fall_edge) begin
        ph_n   = PH_SEG1;
        q_n    = '0;
        ext_n  = '0;
        cut_n  = '0;
        done_n = 1'b1;
      end else begin
        case (ph)
          PH_SEG1: begin
            if (resync) begin
              ext_n  = (perr < jump) ? perr : jump;
              done_n = 1'b1;
            end
            if (qcnt == QW'(ts1) + ext_n) begin
              smp_now = 1'b1;
              ph_n    = PH_SEG2;
              q_n     = '0;
            end else begin
              q_n = qcnt + QW'(1);
            end
          end
          PH_SEG2: begin
            if (resync && (left <= QW'(sjw))) begin
              ph_n   = PH_SEG1;
              q_n    = '0;
              ext_n  = '0;
              cut_n  = '0;
              done_n = 1'b0;
            end else begin
              if (resync) begin
                cut_n  = jump;
                done_n = 1'b1;
              end
              if (qcnt == QW'(ts2) - cut_n) begin
                ph_n = PH_SYNC;
                q_n  = '0;
              end else begin
                q_n = qcnt + QW'(1);
              end
            end
          end
          default: begin
            ph_n   = PH_SEG1;
            q_n    = '0;
            ext_n  = '0;
            cut_n  = '0;
            done_n = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ph   <= PH_SYNC;
      qcnt <= '0;
      ext  <= '0;
      cut  <= '0;
      done <= 1'b0;
    end else begin
      ph   <= ph_n;
      qcnt <= q_n;
      ext  <= ext_n;
      cut  <= cut_n;
      done <= done_n;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic             cfg_we,
  input  logic [BRP_W-1:0] cfg_prescale,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic [TS1_W-1:0] cfg_seg1,
  input  logic [TS2_W-1:0] cfg_seg2,
  input  logic             cfg_triple,
  input  logic             bus_idle,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             bit_val,
  output logic [BRP_W-1:0] rd_prescale,
  output logic [SJW_W-1:0] rd_sjw,
  output logic [TS1_W-1:0] rd_seg1,
  output logic [TS2_W-1:0] rd_seg2,
  output logic             rd_triple
);
  localparam int SEG1_RESET = 3;
  localparam int SEG2_RESET = 2;

  logic tq_tick;
  logic fall_edge;
  logic level;
  logic smp_now;

  can_bt_cfg #(
    .BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W),
    .TS1_RST(SEG1_RESET), .TS2_RST(SEG2_RESET)
  ) u_cfg (
    .clk(clk), .rst(rst), .unlock(cfg_mode), .we(cfg_we),
    .wr_brp(cfg_prescale), .wr_sjw(cfg_sjw), .wr_ts1(cfg_seg1),
    .wr_ts2(cfg_seg2), .wr_tri(cfg_triple),
    .brp(rd_prescale), .sjw(rd_sjw), .ts1(rd_seg1), .ts2(rd_seg2),
    .tri_mode(rd_triple)
  );

  can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk(clk), .rst(rst), .hold(cfg_mode), .brp(rd_prescale), .tick(tq_tick)
  );

  can_bt_sampler u_smp (
    .clk(clk), .rst(rst), .hold(cfg_mode), .tick(tq_tick), .rx_in(rx_in),
    .tri_mode(rd_triple), .fall_edge(fall_edge), .level(level)
  );

  can_bt_engine #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_eng (
    .clk(clk), .rst(rst), .hold(cfg_mode), .tick(tq_tick),
    .fall_edge(fall_edge), .hard_en(bus_idle), .sjw(rd_sjw),
    .ts1(rd_seg1), .ts2(rd_seg2), .smp_now(smp_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_stb <= 1'b0;
      bit_val    <= 1'b1;
    end else begin
      sample_stb <= smp_now;
      if (smp_now) bit_val <= level;
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic             cfg_we,
  input logic             tq_tick,
  input logic             sample_stb,
  input logic             bit_val,
  input logic [BRP_W-1:0] rd_prescale,
  input logic [SJW_W-1:0] rd_sjw,
  input logic [TS1_W-1:0] rd_seg1,
  input logic [TS2_W-1:0] rd_seg2,
  input logic             rd_triple
);
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_mode && cfg_we) |->
      $stable({rd_prescale, rd_sjw, rd_seg1, rd_seg2, rd_triple}));

  assert_no_strobe_in_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_mode) |-> !sample_stb);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  assert_bitval_only_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(bit_val));

  assert_strobe_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(tq_tick));
endmodule

bind can_bit_timer can_bit_timer_chk #(
  .BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
  .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_val(bit_val),
  .rd_prescale(rd_prescale), .rd_sjw(rd_sjw), .rd_seg1(rd_seg1),
  .rd_seg2(rd_seg2), .rd_triple(rd_triple)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mode = 1'b1;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_prescale = '0;
  logic [1:0] cfg_sjw = '0;
  logic [3:0] cfg_seg1 = '0;
  logic [2:0] cfg_seg2 = '0;
  logic       cfg_triple = 1'b0;
  logic       bus_idle = 1'b0;
  logic       rx_in = 1'b1;
  logic       sample_stb, bit_val, rd_triple;
  logic [5:0] rd_prescale;
  logic [1:0] rd_sjw;
  logic [3:0] rd_seg1;
  logic [2:0] rd_seg2;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_prescale(cfg_prescale), .cfg_sjw(cfg_sjw), .cfg_seg1(cfg_seg1),
    .cfg_seg2(cfg_seg2), .cfg_triple(cfg_triple), .bus_idle(bus_idle),
    .rx_in(rx_in), .sample_stb(sample_stb), .bit_val(bit_val),
    .rd_prescale(rd_prescale), .rd_sjw(rd_sjw), .rd_seg1(rd_seg1),
    .rd_seg2(rd_seg2), .rd_triple(rd_triple)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog R1..R12 actual %0d expected <= %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int brp, input int sjw, input int ts1,
                           input int ts2, input bit tri_s);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_prescale = 6'(brp);
    cfg_sjw = 2'(sjw);
    cfg_seg1 = 4'(ts1);
    cfg_seg2 = 3'(ts2);
    cfg_triple = tri_s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int brp, input int sjw, input bit tri_s,
                       input bit rx0, input bit idle);
    @(negedge clk);
    cfg_mode = 1'b1;
    rx_in = rx0;
    bus_idle = idle;
    write_cfg(brp, sjw, 5, 3, tri_s);
    repeat (3) @(negedge clk);
    cfg_mode = 1'b0;
  endtask

  task automatic wait_stb(output int t, output bit v);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_stb && n < 3000);
    check(n < 3000, "strobe timeout R4", n, 3000);
    t = cyc;
    v = bit_val;
  endtask

  task automatic t_reset();
    int seen = 0;
    check(rd_prescale == 0, "R1 prescale", rd_prescale, 0);
    check(rd_sjw == 0, "R1 sjw", rd_sjw, 0);
    check(rd_seg1 == 3, "R1 seg1", rd_seg1, 3);
    check(rd_seg2 == 2, "R1 seg2", rd_seg2, 2);
    check(rd_triple == 0, "R1 triple", rd_triple, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sample_stb) seen++;
    end
    check(seen == 0, "R3 no strobe in cfg mode", seen, 0);
  endtask

  task automatic t_lock();
    int t0, t1;
    bit v;
    setup(0, 1, 1'b0, 1'b1, 1'b0);
    check(rd_sjw == 1 && rd_seg1 == 5 && rd_seg2 == 3, "R2 write in cfg mode",
          rd_seg1, 5);
    write_cfg(9, 3, 1, 0, 1'b1);
    check(rd_prescale == 0, "R2 locked prescale", rd_prescale, 0);
    check(rd_seg1 == 5, "R2 locked seg1", rd_seg1, 5);
    check(rd_triple == 0, "R2 locked triple", rd_triple, 0);
    wait_stb(t0, v);
    wait_stb(t1, v);
    check(t1 - t0 == 11, "R2 timing unchanged after locked write", t1 - t0, 11);
  endtask

  task automatic t_rate(input int brp);
    int t0, t1, t2;
    bit v;
    setup(brp, 1, 1'b0, 1'b1, 1'b0);
    wait_stb(t0, v);
    wait_stb(t1, v);
    wait_stb(t2, v);
    check(t1 - t0 == 11 * (brp + 1), "R4 bit period a", t1 - t0, 11 * (brp + 1));
    check(t2 - t1 == 11 * (brp + 1), "R4 bit period b", t2 - t1, 11 * (brp + 1));
    check(v == 1'b1, "R5 recessive sample", v, 1);
  endtask

  task automatic t_edge(input int sjw, input int d, input int exp,
                        input bit idle, input string tag);
    int t0, t1;
    bit v;
    setup(0, sjw, 1'b0, 1'b1, idle);
    wait_stb(t0, v);
    repeat (d) @(negedge clk);
    rx_in = 1'b0;
    wait_stb(t1, v);
    check(t1 - t0 == exp, tag, t1 - t0, exp);
    check(v == 1'b0, "R5 dominant sample after edge", v, 0);
  endtask

  task automatic t_one_resync();
    int t0, t1;
    bit v;
    setup(0, 1, 1'b0, 1'b1, 1'b0);
    wait_stb(t0, v);
    repeat (4) @(negedge clk);
    rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1;
    @(negedge clk);
    rx_in = 1'b0;
    wait_stb(t1, v);
    check(t1 - t0 == 12, "R9 second edge ignored", t1 - t0, 12);
  endtask

  task automatic t_rising();
    int t0, t1;
    bit v;
    setup(0, 1, 1'b0, 1'b0, 1'b0);
    wait_stb(t0, v);
    check(v == 1'b0, "R5 dominant level", v, 0);
    repeat (6) @(negedge clk);
    rx_in = 1'b1;
    wait_stb(t1, v);
    check(t1 - t0 == 11, "R10 rising edge no resync", t1 - t0, 11);
    check(v == 1'b1, "R10 level after rise", v, 1);
  endtask

  task automatic t_spike(input bit tri_s, input int width, input bit exp,
                         input string tag);
    int t0, t1;
    bit v;
    setup(0, 1, tri_s, 1'b0, 1'b0);
    wait_stb(t0, v);
    repeat (10 - width) @(negedge clk);
    rx_in = 1'b1;
    repeat (width) @(negedge clk);
    rx_in = 1'b0;
    wait_stb(t1, v);
    check(t1 - t0 == 11, "R11 spike bit period", t1 - t0, 11);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_rate(0);
    t_rate(2);
    t_edge(1, 6, 13, 1'b0, "R6 late edge jump-limited");
    t_edge(1, 4, 12, 1'b0, "R6 late edge phase-limited");
    t_edge(0, 6, 12, 1'b0, "R6 late edge jump 1");
    t_edge(1, 3, 11, 1'b0, "R8 edge in sync quantum");
    t_edge(1, 0, 9,  1'b0, "R7 early edge cut by jump");
    t_edge(1, 1, 9,  1'b0, "R7 early edge ends bit");
    t_edge(1, 2, 10, 1'b0, "R7 edge in last seg2 quantum");
    t_one_resync();
    t_rising();
    t_edge(0, 6, 14, 1'b1, "R12 hard sync late");
    t_edge(0, 0, 8,  1'b1, "R12 hard sync early");
    t_spike(1'b0, 1, 1'b1, "R5 single mode takes spike");
    t_spike(1'b1, 1, 1'b0, "R11 majority rejects spike");
    t_spike(1'b1, 2, 1'b1, "R11 majority accepts two quanta");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule